// File: doc/BRIEF.md
# Dual-Mode FIFO with Packet Replay

This block is a single-clock first-in first-out buffer whose read-side behaviour is fixed when master reset is applied. In standard mode the read-side flag reports whether any word is stored. Every word, including the first, is delivered to the data output only on a clock edge where the read request is active. In fall-through mode the read-side flag reports whether the output register holds a valid word. The oldest word is moved to the output without a request, and a read request consumes it and brings the next one forward.

A replay request rewinds the read side to memory location 0 without touching the stored contents, so a packet that has already been read can be delivered again. The write pointer is kept, and the occupancy becomes the write pointer's value. During the short rewind sequence, reads and writes are held off and the read-side flag reports "nothing available". The controller has three states. `ST_RUN` is normal operation. `ST_RWND` rewinds the read pointer and recomputes the occupancy. `ST_PRIME` exists only in fall-through mode and loads location 0 into the output register. The transitions are: master reset goes to `ST_RUN`; `ST_RUN` goes to `ST_RWND` when a replay request is sampled; `ST_RWND` goes back to `ST_RUN` in standard mode or on to `ST_PRIME` in fall-through mode; `ST_PRIME` goes to `ST_RUN`.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode is taken from `mode_sel` on every edge where `mrst_n` is low: 0 selects standard mode and 1 selects fall-through mode. Changes to `mode_sel` while `mrst_n` is high have no effect.
- R2: After reset the FIFO is empty and `rd_data` is 0. In standard mode `rd_flag`=0 and `wr_flag`=1. In fall-through mode `rd_flag`=1 and `wr_flag`=0.
- R3: Standard mode: a read-enabled edge (`rd_en_n`=0) while words are stored loads the oldest word into `rd_data`. `rd_flag` is 1 exactly while at least one word is stored. A read request while empty leaves `rd_data` unchanged.
- R4: Fall-through mode: a word written into an empty FIFO appears on `rd_data` with `rd_flag`=0 after the second edge following the write, with no read request. A read-enabled edge replaces it with the next word. When the last word is consumed, `rd_flag` goes to 1 and `rd_data` holds.
- R5: On an edge with `wr_en_n`=0 and the FIFO not full, `wr_data` is stored in the next sequential location. With `wr_en_n`=1 nothing is stored. A read and a write may both complete on the same edge.
- R6: The FIFO holds DEPTH words in either mode. When full, `wr_flag` is 0 in standard mode and 1 in fall-through mode, and writes are ignored. One completed read clears the full indication.
- R7: `rt_n`=0 sampled on an edge in `ST_RUN` starts a replay. The read pointer returns to location 0 and the occupancy becomes the write pointer's value. The stored words are then delivered again in their original order.
- R8: In standard mode `rd_flag` is 0 for the one cycle after the replay is sampled. It then returns to 1 if words are stored, and the next read returns the word in location 0.
- R9: In fall-through mode `rd_flag` is 1 for two cycles after the replay is sampled. It then returns to 0 with the word in location 0 already on `rd_data`.
- R10: Write and read requests made while the rewind is in progress are ignored. A write on the same edge that samples the replay request is accepted and is included in the replay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| mrst_n | input | 1 | Synchronous master reset, active low |
| mode_sel | input | 1 | Mode select taken during reset: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | WIDTH | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Replay request, active low |
| rd_data | output | WIDTH | Registered output word |
| rd_flag | output | 1 | Standard: 1 = not empty. Fall-through: 0 = output valid |
| wr_flag | output | 1 | Standard: 0 = full. Fall-through: 0 = space available |

## Verification
The collision of interest is a replay request and a write on the same edge. The write must land and become part of the replayed packet, and a write one cycle later, during the rewind, must be dropped. The stimulus table drives `rt_n` low together with `wr_en_n` and a fresh word. The next vector holds a write of a marker value and a read request. The bench reads back the whole packet and confirms that the colliding word arrives last and that the marker never appears, so the flag falls exactly after that word. The rewind is also provoked in fall-through mode, where the bench checks that `rd_flag` stays high for two cycles rather than one.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_RWND  = 2'd1,
        ST_PRIME = 2'd2
    } dmf_state_e;
endpackage

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
    import dmf_pkg::*;
(
    input  logic       clk,
    input  logic       mrst_n,
    input  logic       mode_sel,
    input  logic       rt_n,
    output dmf_state_e state,
    output logic       fwft,
    output logic       run,
    output logic       rewind,
    output logic       prime
);
    dmf_state_e nxt;

    // state register and mode latch
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state <= ST_RUN;
            fwft  <= mode_sel;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (!rt_n) nxt = ST_RWND;
            ST_RWND:  nxt = fwft ? ST_PRIME : ST_RUN;
            ST_PRIME: nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // decoded outputs
    always_comb begin
        run    = 1'b0;
        rewind = 1'b0;
        prime  = 1'b0;
        unique case (state)
            ST_RUN:   run    = 1'b1;
            ST_RWND:  rewind = 1'b1;
            ST_PRIME: prime  = 1'b1;
            default:  run    = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             fwft,
    input  logic             run,
    input  logic             rewind,
    input  logic             prime,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_n,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic [AW-1:0]    wptr,
    output logic             out_valid,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    occ;
    logic             wr_ok, std_rd, consume, fetch, pop;

    assign occ     = count + CW'(out_valid);
    assign full    = (occ == CW'(DEPTH));
    assign wr_ok   = run && !wr_en_n && !full;
    assign std_rd  = run && !fwft && !rd_en_n && (count != '0);
    assign consume = run && fwft && !rd_en_n && out_valid;
    assign fetch   = fwft && (run || prime) && (count != '0) && (!out_valid || consume);
    assign pop     = std_rd || fetch;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            out_valid <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + AW'(1);
            if (rewind) begin
                rptr      <= '0;
                count     <= {1'b0, wptr};
                out_valid <= 1'b0;
            end else begin
                count <= count + CW'(wr_ok) - CW'(pop);
                if (pop) begin
                    rptr    <= rptr + AW'(1);
                    rd_data <= mem[rptr];
                end
                if (fetch)        out_valid <= 1'b1;
                else if (consume) out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             mode_sel,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_n,
    input  logic             rt_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_flag,
    output logic             wr_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    dmf_state_e    state;
    logic          fwft, run, rewind, prime, out_valid, full;
    logic [CW-1:0] count;
    logic [AW-1:0] wptr;

    dmf_ctrl u_ctrl (
        .clk(clk), .mrst_n(mrst_n), .mode_sel(mode_sel), .rt_n(rt_n),
        .state(state), .fwft(fwft), .run(run), .rewind(rewind), .prime(prime)
    );

    dmf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .mrst_n(mrst_n), .fwft(fwft), .run(run), .rewind(rewind),
        .prime(prime), .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .count(count), .wptr(wptr), .out_valid(out_valid),
        .full(full)
    );

    always_comb begin
        if (fwft) begin
            rd_flag = !(run && out_valid);
            wr_flag = full;
        end else begin
            rd_flag = run && (count != '0);
            wr_flag = !full;
        end
    end
endmodule

// File: rtl/dmf_checker.sv
module dmf_checker
    import dmf_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             rt_n,
    input logic             wr_en_n,
    input dmf_state_e       state,
    input logic             fwft,
    input logic [CW-1:0]    count,
    input logic             out_valid,
    input logic [AW-1:0]    wptr,
    input logic [WIDTH-1:0] rd_data
);
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> $stable(fwft)); // R1
    AST_STD_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!mrst_n)
        (!fwft && state == ST_RUN && count == '0) |=> $stable(rd_data)); // R3
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == ST_RUN && wr_en_n) |=> $stable(wptr)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mrst_n)
        (count + CW'(out_valid)) <= CW'(DEPTH)); // R6
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!mrst_n)
        ((count + CW'(out_valid)) == CW'(DEPTH)) |=> $stable(wptr)); // R6
    AST_RT_STARTS: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == ST_RUN && !rt_n) |=> (state == ST_RWND)); // R7
    AST_STD_ONE_STEP: assert property (@(posedge clk) disable iff (!mrst_n)
        (!fwft && state == ST_RWND) |=> (state == ST_RUN)); // R8
    AST_FWFT_PRIMES: assert property (@(posedge clk) disable iff (!mrst_n)
        (fwft && state == ST_RWND) |=> (state == ST_PRIME)); // R9
    AST_PRIME_VALID: assert property (@(posedge clk) disable iff (!mrst_n)
        (state == ST_PRIME && count != '0) |=> out_valid); // R9
    AST_SETUP_NO_WRITE: assert property (@(posedge clk) disable iff (!mrst_n)
        (state != ST_RUN) |=> $stable(wptr)); // R10
endmodule

bind dual_mode_fifo dmf_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .mrst_n(mrst_n), .rt_n(rt_n), .wr_en_n(wr_en_n), .state(state),
    .fwft(fwft), .count(count), .out_valid(out_valid), .wptr(wptr),
    .rd_data(rd_data)
);

// File: tb/dual_mode_fifo_test.sv
`timescale 1ns/1ps
module dual_mode_fifo_test;
    logic       clk = 1'b0;
    logic       mrst_n = 1'b0, mode_sel = 1'b0;
    logic       wr_en_n = 1'b1, rd_en_n = 1'b1, rt_n = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_flag, wr_flag;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    dual_mode_fifo #(.WIDTH(8), .DEPTH(8)) uut (
        .clk(clk), .mrst_n(mrst_n), .mode_sel(mode_sel), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .rt_n(rt_n), .rd_data(rd_data),
        .rd_flag(rd_flag), .wr_flag(wr_flag)
    );

    typedef struct packed {
        logic       wen_n;
        logic [7:0] wd;
        logic       ren_n;
        logic       rtn;
        logic       e_rf;
        logic       e_wf;
        logic       chk_d;
        logic [7:0] e_d;
        logic [3:0] req;
    } vec_t;

    // standard mode, mode_sel held at 1 after reset (R1)
    localparam vec_t VECS [13] = '{
        '{1'b0, 8'hA1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 4'd5},
        '{1'b0, 8'hA2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 4'd5},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA1, 4'd3},
        '{1'b0, 8'hA3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA2, 4'd5},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA3, 4'd3},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA3, 4'd3},
        '{1'b0, 8'hA4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'd8},
        '{1'b0, 8'h55, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA3, 4'd10},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA1, 4'd7},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA2, 4'd7},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA3, 4'd7},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA4, 4'd10},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA4, 4'd10}
    };

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd3:    return "R3";
            4'd5:    return "R5";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wen, input logic [7:0] wd, input logic ren, input logic rt);
        @(negedge clk);
        wr_en_n = wen; wr_data = wd; rd_en_n = ren; rt_n = rt;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic md);
        @(negedge clk);
        mrst_n = 1'b0; mode_sel = md;
        wr_en_n = 1'b1; rd_en_n = 1'b1; rt_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        mrst_n = 1'b1; mode_sel = ~md;
        #1;
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R2 standard reset state
        do_reset(1'b0);
        chk("R2 std rd_flag", {7'd0, rd_flag}, 8'd0);
        chk("R2 std wr_flag", {7'd0, wr_flag}, 8'd1);
        chk("R2 rd_data", rd_data, 8'h00);

        // table walk: standard mode with replay collision (R1 mode_sel now 1)
        for (int i = 0; i < 13; i++) begin
            cyc(VECS[i].wen_n, VECS[i].wd, VECS[i].ren_n, VECS[i].rtn);
            chk({tag_of(VECS[i].req), " rd_flag"}, {7'd0, rd_flag}, {7'd0, VECS[i].e_rf});
            chk({tag_of(VECS[i].req), " wr_flag"}, {7'd0, wr_flag}, {7'd0, VECS[i].e_wf});
            if (VECS[i].chk_d) chk({tag_of(VECS[i].req), " rd_data"}, rd_data, VECS[i].e_d);
        end

        // R6 standard full
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) cyc(1'b0, 8'h10 + 8'(i), 1'b1, 1'b1);
        chk("R6 std full flag", {7'd0, wr_flag}, 8'd0);
        cyc(1'b0, 8'hEE, 1'b1, 1'b1);
        chk("R6 std still full", {7'd0, wr_flag}, 8'd0);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R6 std first out", rd_data, 8'h10);
        chk("R6 std full cleared", {7'd0, wr_flag}, 8'd1);
        for (int i = 1; i < 8; i++) begin
            cyc(1'b1, 8'h00, 1'b0, 1'b1);
            chk("R6 std order", rd_data, 8'h10 + 8'(i));
        end
        chk("R6 std empty after 8", {7'd0, rd_flag}, 8'd0);

        // R2 / R4 / R9 fall-through
        do_reset(1'b1);
        chk("R2 fwft rd_flag", {7'd0, rd_flag}, 8'd1);
        chk("R2 fwft wr_flag", {7'd0, wr_flag}, 8'd0);
        cyc(1'b0, 8'hB1, 1'b1, 1'b1);
        chk("R4 not yet shown", {7'd0, rd_flag}, 8'd1);
        cyc(1'b1, 8'h00, 1'b1, 1'b1);
        chk("R4 auto shown flag", {7'd0, rd_flag}, 8'd0);
        chk("R4 auto shown data", rd_data, 8'hB1);
        cyc(1'b0, 8'hB2, 1'b1, 1'b1);
        cyc(1'b0, 8'hB3, 1'b1, 1'b1);
        chk("R4 head kept", rd_data, 8'hB1);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R4 advance 2", rd_data, 8'hB2);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R4 advance 3", rd_data, 8'hB3);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R4 drained flag", {7'd0, rd_flag}, 8'd1);
        chk("R4 drained data", rd_data, 8'hB3);
        cyc(1'b1, 8'h00, 1'b1, 1'b0);
        chk("R9 setup flag 1", {7'd0, rd_flag}, 8'd1);
        cyc(1'b1, 8'h00, 1'b1, 1'b1);
        chk("R9 setup flag 2", {7'd0, rd_flag}, 8'd1);
        cyc(1'b1, 8'h00, 1'b1, 1'b1);
        chk("R9 ready flag", {7'd0, rd_flag}, 8'd0);
        chk("R9 first location", rd_data, 8'hB1);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R7 fwft replay 2", rd_data, 8'hB2);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R7 fwft replay 3", rd_data, 8'hB3);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R7 fwft replay end", {7'd0, rd_flag}, 8'd1);

        // R6 fall-through full
        do_reset(1'b1);
        for (int i = 0; i < 8; i++) cyc(1'b0, 8'h40 + 8'(i), 1'b1, 1'b1);
        chk("R6 fwft full flag", {7'd0, wr_flag}, 8'd1);
        cyc(1'b0, 8'hEE, 1'b1, 1'b1);
        chk("R6 fwft head", rd_data, 8'h40);
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R6 fwft full cleared", {7'd0, wr_flag}, 8'd0);
        chk("R6 fwft next", rd_data, 8'h41);
        for (int i = 2; i < 8; i++) begin
            cyc(1'b1, 8'h00, 1'b0, 1'b1);
            chk("R6 fwft order", rd_data, 8'h40 + 8'(i));
        end
        cyc(1'b1, 8'h00, 1'b0, 1'b1);
        chk("R6 fwft dropped write absent", {7'd0, rd_flag}, 8'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule